// File: doc/BRIEF.md
# Busy-Indicator SAR Converter Read Controller

This block runs one conversion and one readback on an 18-bit serial successive-approximation converter. The converter is wired in its four-wire mode with a busy indicator. The controller owns the convert line, the data-in line and the serial clock. It watches the shared serial data line, which a pull-up holds high while the converter's output is released.

A one-cycle `start` request while idle raises the convert line with data-in still high. That edge starts a conversion and selects the chip-select style read. A few cycles later, well inside the minimum conversion time, the controller pulls data-in low. Data-in then stays low until the readback ends.

The end of conversion is not timed. The converter drives the data line low when it finishes, and the controller sees that low through a two-flop synchroniser. It then produces serial clocks from a divider of the system clock. It samples one bit a fixed number of system clocks after each falling edge, most significant bit first, into a shift register. After the last bit it raises data-in and drops the convert line, which releases the converter's output. In the same cycle it pulses `result_valid` with the word. If no busy-low arrives inside the maximum conversion time plus a margin, it pulses `timeout` and goes back to idle.

Top module: `sar_busy_reader`

## Requirements
- R1: Out of reset and whenever idle, the outputs are sdi_out=1, cnv_out=0, sck_out=0, result_valid=0 and timeout=0, and result_data reads 0 after reset. When start is 1 on a clock edge in idle, cnv_out goes to 1 on that edge and sdi_out stays 1.
- R2: Count the cycles from the one in which cnv_out first reads 1. sdi_out is 1 for the first SDI_HIGH cycles, where SDI_HIGH = T_CONV_MIN/4 with a minimum of 1 (5 with the defaults). From then on it is 0 for the rest of the conversion and the readback, so it is always low before T_CONV_MIN cycles have passed.
- R3: sdo_in passes through a two-flop synchroniser. A low on the synchroniser output is taken as end of conversion only from conversion cycle SDI_HIGH+2 onward. A low that reaches the synchroniser output earlier is ignored and starts no serial clock.
- R4: Once end of conversion is accepted, sck_out alternates SCK_HALF system clocks high and SCK_HALF low; the first high phase is one cycle shorter. The controller samples the synchronised data line SAMPLE_LAG cycles after each of the first DATA_W falling edges of sck_out. The first sampled bit becomes result_data[DATA_W-1] and the last becomes result_data[0].
- R5: With EXTRA_FALL=1, one further falling edge is issued after the DATA_W-th, and its bit is not sampled. A frame therefore has DATA_W+1 falling edges. With EXTRA_FALL=0 it has DATA_W.
- R6: When the readback ends, result_valid is 1 for exactly one cycle, with sdi_out=1, cnv_out=0 and result_data holding the word. result_data keeps that word until the next accepted start clears it.
- R7: A conversion window lasts LIMIT = T_CONV_MAX+TO_MARGIN cycles (76 with the defaults), counted from the first convert-high cycle. If the synchronised line has not been low during any of those cycles, the next cycle shows timeout=1 for one cycle. In that cycle cnv_out=0, sdi_out=1 and result_valid=0. No serial clock is issued and the block returns to idle. A low that reaches the synchroniser output during the last counted cycle is still accepted.
- R8: start is ignored in every state other than idle. A pulse during conversion or readback changes neither the word, the frame length nor the number of result_valid pulses.
- R9: cnv_out stays 1 without a break from the start edge until the cycle of result_valid or timeout, and it falls only in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request one conversion and readback; honoured only in idle |
| sdo_in | input | 1 | Converter serial data line; reads high when released |
| cnv_out | output | 1 | Convert line to the converter |
| sdi_out | output | 1 | Data-in line to the converter; frames conversion and read |
| sck_out | output | 1 | Serial clock to the converter |
| result_data | output | DATA_W | Last word read, most significant bit first on the wire |
| result_valid | output | 1 | One-cycle strobe when result_data holds a new word |
| timeout | output | 1 | One-cycle strobe when no end of conversion was seen |

## Verification
The bench runs a converter model that drives a new bit on each falling serial clock edge and releases the line on the extra edge or when data-in rises. Against it, the bench reads alternating, all-ones, lone-LSB and lone-MSB words, so a design that is off by one bit would show a shifted or truncated word, and one that sampled too soon after the edge would show the previous bit.

One case holds the data line low while data-in is still high. A design that took any low as end of conversion would start clocking inside that window. Two cases place the busy-low right at the edge of the conversion window, at negedge 74 and at negedge 75 after the start edge: the first must still read and the second must time out, so an off-by-one window counter fails one of them. A final case pulses start during conversion and again during readback. A design that restarted on it would clear the word or issue a second valid strobe.

// File: rtl/sar_busy_reader_pkg.sv
// Package: shared types of the busy-indicator read controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_busy_reader_pkg;

    // Sequencer states: idle, converting, reading bits, extra edge, result, fault.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CONV  = 3'd1,
        ST_READ  = 3'd2,
        ST_TAIL  = 3'd3,
        ST_DONE  = 3'd4,
        ST_FAULT = 3'd5
    } rd_state_t;

endpackage

// File: rtl/sar_busy_reader_sync.sv
// Module: multi-flop synchroniser for the asynchronous serial data line.
// Assumes: STAGES >= 2; RST_VAL is the level the line rests at (pulled up).
module sar_busy_reader_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/sar_busy_reader_sckgen.sv
// Module: serial clock divider. While run is high, it produces HALF cycles
// high then HALF cycles low, and strobes sample_stb LAG cycles after each
// registered falling edge.
// Assumes: HALF >= 2, 1 <= LAG <= HALF; sck is registered and glitch free.
module sar_busy_reader_sckgen #(
    parameter int HALF = 4,
    parameter int LAG  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic sample_stb
);

    localparam int PH_W = $clog2(2 * HALF);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(2 * HALF - 1);
    localparam logic [PH_W-1:0] PH_HALF  = PH_W'(HALF);
    localparam logic [PH_W-1:0] PH_SMPL  = PH_W'(HALF + LAG - 1);

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] phase_n;

    // Next phase: wrap over one full serial period, park at zero when stopped.
    always_comb begin
        if (!run) begin
            phase_n = '0;
        end else if (phase == PH_LAST) begin
            phase_n = '0;
        end else begin
            phase_n = phase + 1'b1;
        end
    end

    // Phase register and registered clock level (high in the first half).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            sck   <= 1'b0;
        end else begin
            phase <= phase_n;
            sck   <= run && (phase_n < PH_HALF);
        end
    end

    assign sample_stb = run && (phase == PH_SMPL);

endmodule

// File: rtl/sar_busy_reader_shift.sv
// Module: serial-in shift register collecting the result, MSB first.
// Assumes: clear has priority over shift_en; W >= 2.
module sar_busy_reader_shift #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);

    // Clear on a new frame, else shift one bit in at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clear) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/sar_busy_reader_seq.sv
// Module: sequencer. It frames a conversion with the convert and data-in
// lines, waits for the busy-low, counts bits and raises the result or fault
// strobes. All line outputs are registered from the next-state values.
// Assumes: SDI_HIGH < ACCEPT_AT < LIMIT; line_low is already synchronised.
module sar_busy_reader_seq
    import sar_busy_reader_pkg::*;
#(
    parameter int DATA_W     = 18,
    parameter int SDI_HIGH   = 5,
    parameter int ACCEPT_AT  = 7,
    parameter int LIMIT      = 76,
    parameter int EXTRA_FALL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic line_low,
    input  logic sample_stb,
    output logic cnv,
    output logic sdi,
    output logic run,
    output logic clear,
    output logic shift_en,
    output logic valid,
    output logic fault
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(LIMIT - 1);
    localparam logic [CNT_W-1:0] CNT_ACCEPT = CNT_W'(ACCEPT_AT);
    localparam logic [CNT_W-1:0] CNT_SDI    = CNT_W'(SDI_HIGH);
    localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(DATA_W - 1);

    rd_state_t        state, state_n, after_last;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [BIT_W-1:0] bits;
    logic             accept;

    // Pick what follows the last sampled bit: an extra edge or straight to done.
    generate
        if (EXTRA_FALL != 0) begin : g_tail
            assign after_last = ST_TAIL;
        end else begin : g_no_tail
            assign after_last = ST_DONE;
        end
    endgenerate

    assign accept = (cnt >= CNT_ACCEPT) && line_low;

    // Next-state decision for one conversion-and-read cycle.
    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:  if (start) state_n = ST_CONV;
            ST_CONV:  begin
                if (accept) begin
                    state_n = ST_READ;
                end else if (cnt == CNT_LAST) begin
                    state_n = ST_FAULT;
                end
            end
            ST_READ:  if (sample_stb && (bits == BIT_LAST)) state_n = after_last;
            ST_TAIL:  if (sample_stb) state_n = ST_DONE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // Conversion-window counter: counts convert-high cycles while converting.
    always_comb begin
        if (state_n == ST_CONV && state == ST_CONV) begin
            cnt_n = cnt + 1'b1;
        end else begin
            cnt_n = '0;
        end
    end

    // State, counters and registered line outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bits  <= '0;
            cnv   <= 1'b0;
            sdi   <= 1'b1;
            valid <= 1'b0;
            fault <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (state != ST_READ) begin
                bits <= '0;
            end else if (sample_stb) begin
                bits <= bits + 1'b1;
            end
            cnv   <= (state_n == ST_CONV) || (state_n == ST_READ) || (state_n == ST_TAIL);
            sdi   <= (state_n == ST_IDLE) || (state_n == ST_DONE) || (state_n == ST_FAULT)
                     || ((state_n == ST_CONV) && (cnt_n < CNT_SDI));
            valid <= (state_n == ST_DONE);
            fault <= (state_n == ST_FAULT);
        end
    end

    assign run      = (state == ST_READ) || (state == ST_TAIL);
    assign shift_en = (state == ST_READ) && sample_stb;
    assign clear    = (state == ST_IDLE) && start;

endmodule

// File: rtl/sar_busy_reader.sv
// Module: top of the busy-indicator read controller. It ties together the
// synchroniser, sequencer, serial clock divider and result shift register.
// Assumes: the data line is pulled high when released; timing parameters
// are in system clocks; SAMPLE_LAG >= 3 to cover the synchroniser latency.
module sar_busy_reader #(
    parameter int DATA_W     = 18,
    parameter int T_CONV_MIN = 20,
    parameter int T_CONV_MAX = 60,
    parameter int TO_MARGIN  = 16,
    parameter int SCK_HALF   = 4,
    parameter int SAMPLE_LAG = 3,
    parameter int EXTRA_FALL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sdo_in,
    output logic              cnv_out,
    output logic              sdi_out,
    output logic              sck_out,
    output logic [DATA_W-1:0] result_data,
    output logic              result_valid,
    output logic              timeout
);

    localparam int SYNC_STAGES = 2;
    localparam int SDI_HIGH    = (T_CONV_MIN >= 8) ? (T_CONV_MIN / 4) : 1;
    localparam int ACCEPT_AT   = SDI_HIGH + SYNC_STAGES;
    localparam int LIMIT       = T_CONV_MAX + TO_MARGIN;

    logic line_sync;
    logic run;
    logic sample_stb;
    logic clear;
    logic shift_en;

    sar_busy_reader_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sdo_in),
        .q     (line_sync)
    );

    sar_busy_reader_seq #(
        .DATA_W     (DATA_W),
        .SDI_HIGH   (SDI_HIGH),
        .ACCEPT_AT  (ACCEPT_AT),
        .LIMIT      (LIMIT),
        .EXTRA_FALL (EXTRA_FALL)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .line_low   (!line_sync),
        .sample_stb (sample_stb),
        .cnv        (cnv_out),
        .sdi        (sdi_out),
        .run        (run),
        .clear      (clear),
        .shift_en   (shift_en),
        .valid      (result_valid),
        .fault      (timeout)
    );

    sar_busy_reader_sckgen #(
        .HALF (SCK_HALF),
        .LAG  (SAMPLE_LAG)
    ) u_sck (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .sck        (sck_out),
        .sample_stb (sample_stb)
    );

    sar_busy_reader_shift #(
        .W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (shift_en),
        .bit_in   (line_sync),
        .word     (result_data)
    );

endmodule

// File: rtl/sar_busy_reader_chk.sv
// Module: protocol checker for the read controller, bound to the top.
// Assumes: sees only the top-level ports; counters are local to the checker.
module sar_busy_reader_chk #(
    parameter int DATA_W     = 18,
    parameter int T_CONV_MIN = 20,
    parameter int EXTRA_FALL = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnv_out,
    input logic              sdi_out,
    input logic              sck_out,
    input logic [DATA_W-1:0] result_data,
    input logic              result_valid,
    input logic              timeout
);

    int unsigned hi_cyc;
    int unsigned fall_cnt;
    logic        sck_d;

    // Count convert-high cycles (saturating) and serial clock falls per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cyc   <= 0;
            fall_cnt <= 0;
            sck_d    <= 1'b0;
        end else begin
            sck_d <= sck_out;
            if (!cnv_out) begin
                hi_cyc <= 0;
            end else if (hi_cyc < T_CONV_MIN) begin
                hi_cyc <= hi_cyc + 1;
            end
            if (!cnv_out) begin
                fall_cnt <= 0;
            end else if (sck_d && !sck_out) begin
                fall_cnt <= fall_cnt + 1;
            end
        end
    end

    AST_CNV_RISE_SDI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_out) |-> sdi_out);                                     // R1
    AST_SDI_LOW_BY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_out && hi_cyc >= T_CONV_MIN) |-> !sdi_out);                 // R2
    AST_SCK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sck_out |-> cnv_out);                                            // R4
    AST_FALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt <= DATA_W + EXTRA_FALL);                                // R5
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);                                 // R6
    AST_VALID_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (sdi_out && !cnv_out));                         // R6
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnv_out && $past(!cnv_out)) |-> $stable(result_data));         // R6
    AST_TIMEOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!cnv_out && sdi_out && !result_valid));             // R7
    AST_CNV_ENDS_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_out) |-> (result_valid || timeout));                   // R9

endmodule

bind sar_busy_reader sar_busy_reader_chk #(
    .DATA_W     (DATA_W),
    .T_CONV_MIN (T_CONV_MIN),
    .EXTRA_FALL (EXTRA_FALL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnv_out      (cnv_out),
    .sdi_out      (sdi_out),
    .sck_out      (sck_out),
    .result_data  (result_data),
    .result_valid (result_valid),
    .timeout      (timeout)
);

// File: tb/sar_busy_reader_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios against a behavioural busy-indicator converter.
module sar_busy_reader_test;

    localparam int DW      = 18;
    localparam int HALF    = 4;
    localparam int SDI_HI  = 5;   // T_CONV_MIN/4 with default 20
    localparam int TO_NEG  = 77;  // negedge after start edge showing timeout

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sdo_in = 1'b1;
    logic          cnv_out, sdi_out, sck_out, result_valid, timeout;
    logic [DW-1:0] result_data;

    int total = 0;
    int bad   = 0;

    logic [DW-1:0] mdl_word = '0;
    int            mdl_falls = 0;

    sar_busy_reader uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .sdo_in       (sdo_in),
        .cnv_out      (cnv_out),
        .sdi_out      (sdi_out),
        .sck_out      (sck_out),
        .result_data  (result_data),
        .result_valid (result_valid),
        .timeout      (timeout)
    );

    always #2 clk = ~clk;

    // Converter model: present the next bit on each falling serial clock edge;
    // release the line on the extra edge.
    always @(negedge sck_out) begin
        if (cnv_out) begin
            mdl_falls = mdl_falls + 1;
            #1;
            if (mdl_falls <= DW) sdo_in = mdl_word[DW - mdl_falls];
            else                 sdo_in = 1'b1;
        end
    end

    // Converter model: data-in rising releases the line.
    always @(posedge sdi_out) begin
        #1 sdo_in = 1'b1;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reset scenario: idle levels after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", "reset sdi", {31'd0, sdi_out}, 1);
        check("R1", "reset cnv", {31'd0, cnv_out}, 0);
        check("R1", "reset sck", {31'd0, sck_out}, 0);
        check("R1", "reset valid", {31'd0, result_valid}, 0);
        check("R1", "reset timeout", {31'd0, timeout}, 0);
        check("R1", "reset data", {14'd0, result_data}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Read scenario: busy-low driven at negedge `dly` after the start edge;
    // optional early glitch while data-in is high and optional stray starts.
    task automatic t_read(input logic [DW-1:0] word, input int dly,
                          input bit glitch, input bit poke);
        int  n = 1;
        int  sdi_hi = 0;
        int  first_sck = 0;
        int  hi_run = 0;
        int  last_run = 0;
        int  valids = 0;
        bit  cnv_drop = 0;
        bit  saw_to = 0;
        mdl_word = word;
        mdl_falls = 0;
        sdo_in = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1", "cnv after start", {31'd0, cnv_out}, 1);
        check("R1", "sdi at cnv rise", {31'd0, sdi_out}, 1);
        while (!result_valid && n < 2000) begin
            if (cnv_out && sdi_out) sdi_hi++;
            if (!cnv_out) cnv_drop = 1;
            if (timeout) saw_to = 1;
            if (sck_out && first_sck == 0) first_sck = n;
            if (sck_out) hi_run++;
            else if (hi_run != 0) begin
                last_run = hi_run;
                hi_run = 0;
            end
            start = 1'b0;
            if (glitch && n >= 1 && n <= 3) sdo_in = 1'b0;
            if (glitch && n == 4) sdo_in = 1'b1;
            if (n == dly) sdo_in = 1'b0;
            if (poke && (n == dly / 2 || n == dly + 40)) start = 1'b1;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check("R2", "sdi high cycles", sdi_hi, SDI_HI);
        check("R3", "no sck before busy-low", {31'd0, first_sck > dly}, 1);
        check("R4", "serial high phase", last_run, HALF);
        check("R4", "word", {14'd0, result_data}, {14'd0, word});
        check("R5", "falling edges", mdl_falls, DW + 1);
        check("R6", "valid frame sdi", {31'd0, sdi_out}, 1);
        check("R6", "valid frame cnv", {31'd0, cnv_out}, 0);
        check("R9", "cnv held", {31'd0, cnv_drop}, 0);
        check("R7", "no timeout on read", {31'd0, saw_to}, 0);
        valids = 1;
        repeat (5) begin
            @(negedge clk);
            if (result_valid) valids++;
        end
        check("R6", "single valid", valids, 1);
        check("R6", "word held", {14'd0, result_data}, {14'd0, word});
        if (poke) check("R8", "stray start ignored", {14'd0, result_data}, {14'd0, word});
        check("R8", "idle after read", {31'd0, cnv_out}, 0);
    endtask

    // Timeout scenario: busy-low never comes, or comes too late (late > 0).
    task automatic t_timeout(input int late);
        int n = 1;
        int to_at = 0;
        bit sck_seen = 0;
        bit val_seen = 0;
        sdo_in = 1'b1;
        mdl_falls = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!timeout && n < 300) begin
            if (sck_out) sck_seen = 1;
            if (result_valid) val_seen = 1;
            if (late > 0 && n == late) sdo_in = 1'b0;
            @(negedge clk);
            n++;
        end
        to_at = n;
        check("R7", "timeout cycle", to_at, TO_NEG);
        check("R7", "timeout cnv", {31'd0, cnv_out}, 0);
        check("R7", "timeout sdi", {31'd0, sdi_out}, 1);
        check("R7", "timeout no valid", {31'd0, val_seen | result_valid}, 0);
        check("R7", "timeout no sck", {31'd0, sck_seen}, 0);
        @(negedge clk);
        check("R7", "timeout one cycle", {31'd0, timeout}, 0);
        check("R9", "idle after timeout", {31'd0, cnv_out}, 0);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_read(18'h2AAAA, 30, 1'b0, 1'b0);
        t_read(18'h15555, 10, 1'b0, 1'b0);
        t_read(18'h3FFFF, 40, 1'b0, 1'b0);
        t_read(18'h00001, 30, 1'b1, 1'b0);  // R3: early low ignored
        t_read(18'h20000, 74, 1'b0, 1'b0);  // R7: last accepted cycle
        t_timeout(75);                      // R7: one cycle too late
        t_timeout(0);                       // R7: never low
        t_read(18'h1C3A5, 50, 1'b0, 1'b1);  // R8: stray starts
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule